// File: doc/BRIEF.md
# Tone-Bit Clock Recovery and NRZI Octet Assembler

This block sits behind a two-tone demodulator that has already turned each audio sample into a hard decision: one bit per sample, which says which tone is currently stronger. At the default rate of eight samples per baud, the block recovers the symbol timing. A small phase accumulator runs at sample rate and is pulled slightly toward the centre of its range whenever the hard bit changes. When the accumulator wraps, one symbol period ends, and the symbol is decided by a majority vote over the three newest samples.

Each decided symbol is compared with the one before it to undo NRZI line coding. The resulting data bits are gathered into octets, first received bit in bit 0. Each finished octet is offered downstream with a one-cycle valid pulse. When the downstream queue reports full, the octet is thrown away and assembly continues with the next one. Frame delimiting, bit de-stuffing and checksum work belong to later stages.

Top module: `tone_bit_sync`

## Requirements
- R1: After reset, `oct_valid` is 0 and `oct_data` is 8'h00; sample history, previous decided symbol, phase, bit count and octet shift register all start at zero.
- R2: The phase advances by 8 on every accepted sample. When it reaches 64 or more it is reduced by 64 and a symbol period ends, so a run of identical samples ends one symbol every 8 samples.
- R3: A transition is an accepted sample that differs from the previous accepted sample. On a transition the phase first moves by +1 when it is below 32, and by -1 otherwise, before the regular advance.
- R4: At a symbol end, the decided symbol is 1 when at least two of the three newest accepted samples, including the current one, are 1.
- R5: The data bit is 1 when the decided symbol equals the previous decided symbol, and 0 when they differ. The previous symbol is 0 after reset.
- R6: Data bits enter the octet from the top and shift toward bit 0, so the first of the eight bits lands in `oct_data[0]` and the last in `oct_data[7]`.
- R7: Every eighth data bit completes an octet. `oct_valid` is then high for exactly the one clock that follows the edge on which the completing sample was accepted, with `oct_data` holding the octet. At all other times it is low.
- R8: If `q_full` is high together with the completing sample, no pulse is produced and `oct_data` keeps its old value. The bit count still restarts, so the next octet is complete eight data bits later.
- R9: The block ignores `rx_bit` and `q_full` on clocks when `rx_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | One-clock strobe: a new hard sample is present |
| rx_bit | input | 1 | Hard tone decision for this sample |
| q_full | input | 1 | Downstream queue is full; a completed octet is dropped |
| oct_data | output | 8 | Last delivered octet, first bit in bit 0 |
| oct_valid | output | 1 | One-clock pulse marking a delivered octet |

## Verification
Every result of the block shows up exactly one clock after the strobe that causes it. The phase, the vote and the NRZI decision all act within the accepting edge, and only the octet output is registered. The bench drives each strobe for one clock from a falling edge and compares `oct_valid` and `oct_data` on the next falling edge against a bench model stepped on the same sample. On every idle clock between strobes it also requires `oct_valid` to be low. Symbol timing is checked in directed runs by counting samples up to each pulse: pulses must fall on sample 64 and 128 of a steady run, and the dropped octet is confirmed by the next pulse arriving 64 samples later.

// File: rtl/tone_bit_sync_pkg.sv
package tone_bit_sync_pkg;

   typedef enum logic {
      PACK_LSB_FIRST = 1'b0,
      PACK_MSB_FIRST = 1'b1
   } pack_order_e;

   function automatic int unsigned vote_threshold(input int unsigned taps);
      return (taps + 1) / 2;
   endfunction

endpackage

// File: rtl/tbs_sample_window.sv
module tbs_sample_window #(
   parameter int unsigned WIN = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stb,
   input  logic           bit_in,
   output logic [WIN-1:0] window,
   output logic           trans
);
   localparam int unsigned HW = WIN - 1;

   logic [HW-1:0] hist;

   generate
      if (WIN < 3) begin : g_bad_win
         $error("tbs_sample_window: WIN must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (stb) begin
         hist <= {hist[HW-2:0], bit_in};
      end
   end

   always_comb begin
      window = {hist, bit_in};
      trans  = bit_in ^ hist[0];
   end

   assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(hist));

endmodule

// File: rtl/tbs_phase_tracker.sv
module tbs_phase_tracker #(
   parameter int unsigned SPB  = 8,
   parameter int unsigned STEP = 8,
   parameter int unsigned PW   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic trans,
   output logic sym_end
);
   localparam int unsigned SPAN = SPB * STEP;

   localparam logic signed [PW-1:0] STEP_S = PW'(STEP);
   localparam logic signed [PW-1:0] SPAN_S = PW'(SPAN);
   localparam logic signed [PW-1:0] HALF_S = PW'(SPAN / 2);
   localparam logic signed [PW-1:0] ONE_S  = PW'(1);

   logic signed [PW-1:0] phase;
   logic signed [PW-1:0] nudge;
   logic signed [PW-1:0] sum;
   logic                 wrap;

   generate
      if (SPAN + STEP + 1 >= (1 << (PW - 1))) begin : g_bad_pw
         $error("tbs_phase_tracker: PW too narrow for SPB*STEP");
      end
      if (STEP < 2) begin : g_bad_step
         $error("tbs_phase_tracker: STEP must exceed the nudge");
      end
   endgenerate

   always_comb begin
      if (!trans) begin
         nudge = '0;
      end else if (phase < HALF_S) begin
         nudge = ONE_S;
      end else begin
         nudge = -ONE_S;
      end
      sum     = phase + nudge + STEP_S;
      wrap    = (sum >= SPAN_S);
      sym_end = stb & wrap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (stb) begin
         phase <= wrap ? (sum - SPAN_S) : sum;
      end
   end

   assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase >= 0) && (phase < SPAN_S));

   assert_after_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sym_end |=> (phase < STEP_S));

   assert_nudge_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && trans && (phase < HALF_S)) |=> (phase == $past(phase) + STEP_S + ONE_S));

   assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(phase));

endmodule

// File: rtl/tbs_symbol_slicer.sv
module tbs_symbol_slicer
   import tone_bit_sync_pkg::*;
#(
   parameter int unsigned WIN = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sym_end,
   input  logic [WIN-1:0] window,
   output logic           data_bit,
   output logic           data_vld
);
   localparam int unsigned THR = vote_threshold(WIN);
   localparam int unsigned CW  = $clog2(WIN + 1);

   logic          prev_sym;
   logic          sym;
   logic [CW-1:0] ones;

   generate
      if ((WIN % 2) == 0) begin : g_bad_win
         $error("tbs_symbol_slicer: WIN must be odd for a clean vote");
      end
   endgenerate

   always_comb begin
      ones = '0;
      for (int i = 0; i < WIN; i++) begin
         ones = ones + CW'(window[i]);
      end
      sym      = (ones >= CW'(THR));
      data_bit = (sym == prev_sym);
      data_vld = sym_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sym <= 1'b0;
      end else if (sym_end) begin
         prev_sym <= sym;
      end
   end

   assert_prev_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_end |=> $stable(prev_sym));

endmodule

// File: rtl/tbs_octet_packer.sv
module tbs_octet_packer
   import tone_bit_sync_pkg::*;
#(
   parameter int unsigned BW    = 8,
   parameter pack_order_e ORDER = PACK_LSB_FIRST
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          data_vld,
   input  logic          data_bit,
   input  logic          q_full,
   output logic [BW-1:0] oct_data,
   output logic          oct_valid
);
   localparam int unsigned CW = $clog2(BW);
   localparam logic [CW-1:0] LAST = CW'(BW - 1);

   logic [BW-1:0] shreg;
   logic [BW-1:0] shreg_nx;
   logic [CW-1:0] cnt;
   logic          done;

   generate
      if (BW < 2) begin : g_bad_bw
         $error("tbs_octet_packer: BW must be at least 2");
      end
      if (ORDER == PACK_LSB_FIRST) begin : g_lsb
         always_comb shreg_nx = {data_bit, shreg[BW-1:1]};
      end else begin : g_msb
         always_comb shreg_nx = {shreg[BW-2:0], data_bit};
      end
   endgenerate

   always_comb done = data_vld && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         cnt       <= '0;
         oct_data  <= '0;
         oct_valid <= 1'b0;
      end else begin
         oct_valid <= 1'b0;
         if (data_vld) begin
            shreg <= shreg_nx;
            cnt   <= done ? '0 : cnt + 1'b1;
            if (done && !q_full) begin
               oct_data  <= shreg_nx;
               oct_valid <= 1'b1;
            end
         end
      end
   end

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oct_valid |=> !oct_valid);

   assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && q_full) |=> (!oct_valid && $stable(oct_data)));

   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cnt == '0));

   assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> !oct_valid);

endmodule

// File: rtl/tone_bit_sync.sv
module tone_bit_sync
   import tone_bit_sync_pkg::*;
#(
   parameter int unsigned SPB   = 8,
   parameter int unsigned STEP  = 8,
   parameter int unsigned PW    = 8,
   parameter int unsigned WIN   = 3,
   parameter int unsigned BW    = 8,
   parameter pack_order_e ORDER = PACK_LSB_FIRST
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_stb,
   input  logic          rx_bit,
   input  logic          q_full,
   output logic [BW-1:0] oct_data,
   output logic          oct_valid
);
   logic [WIN-1:0] window;
   logic           trans;
   logic           sym_end;
   logic           data_bit;
   logic           data_vld;

   tbs_sample_window #(.WIN(WIN)) i_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (rx_stb),
      .bit_in (rx_bit),
      .window (window),
      .trans  (trans)
   );

   tbs_phase_tracker #(.SPB(SPB), .STEP(STEP), .PW(PW)) i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (rx_stb),
      .trans   (trans),
      .sym_end (sym_end)
   );

   tbs_symbol_slicer #(.WIN(WIN)) i_slicer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_end  (sym_end),
      .window   (window),
      .data_bit (data_bit),
      .data_vld (data_vld)
   );

   tbs_octet_packer #(.BW(BW), .ORDER(ORDER)) i_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_vld  (data_vld),
      .data_bit  (data_bit),
      .q_full    (q_full),
      .oct_data  (oct_data),
      .oct_valid (oct_valid)
   );

   assert_end_needs_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sym_end |-> rx_stb);

endmodule

// File: tb/test_tone_bit_sync.sv
module test_tone_bit_sync;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_stb = 1'b0;
   logic       rx_bit = 1'b0;
   logic       q_full = 1'b0;
   logic [7:0] oct_data;
   logic       oct_valid;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   int unsigned cyc      = 0;

   // bench model state
   logic [1:0] m_hist;
   int         m_ph;
   logic       m_prev;
   logic [7:0] m_oct;
   int         m_cnt;
   logic [7:0] m_last;

   tone_bit_sync i_tone_bit_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_stb    (rx_stb),
      .rx_bit    (rx_bit),
      .q_full    (q_full),
      .oct_data  (oct_data),
      .oct_valid (oct_valid)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_checks = n_checks + 1;
         n_fail   = n_fail + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_hist = '0; m_ph = 0; m_prev = 1'b0; m_oct = '0; m_cnt = 0; m_last = '0;
   endtask

   // one accepted sample through the requirement model
   task automatic model_step(input logic b, input logic qf,
                             output logic ev, output logic [7:0] eb);
      int   ones;
      int   sum;
      logic d;
      logic nr;
      ev   = 1'b0;
      ones = int'(b) + int'(m_hist[0]) + int'(m_hist[1]);
      sum  = m_ph + 8;
      if (b != m_hist[0]) sum = sum + ((m_ph < 32) ? 1 : -1);
      m_hist = {m_hist[0], b};
      if (sum >= 64) begin
         m_ph   = sum - 64;
         d      = (ones >= 2);
         nr     = (d == m_prev);
         m_prev = d;
         m_oct  = {nr, m_oct[7:1]};
         if (m_cnt == 7) begin
            m_cnt = 0;
            if (!qf) begin
               ev     = 1'b1;
               m_last = m_oct;
            end
         end else begin
            m_cnt = m_cnt + 1;
         end
      end else begin
         m_ph = sum;
      end
      eb = m_last;
   endtask

   // drive one strobe, then 'gap' idle clocks; all checks away from posedge
   task automatic sample(input logic b, input logic qf, input int gap,
                         input string req, output logic got_vld);
      logic       ev;
      logic [7:0] eb;
      @(negedge clk);
      rx_stb = 1'b1; rx_bit = b; q_full = qf;
      model_step(b, qf, ev, eb);
      @(negedge clk);
      rx_stb  = 1'b0;
      got_vld = oct_valid;
      check(oct_valid == ev, req, "R7 R2 R3 R8 pulse timing", int'(oct_valid), int'(ev));
      if (ev)
         check(oct_data == eb, req, "R4 R5 R6 octet value", int'(oct_data), int'(eb));
      for (int g = 0; g < gap; g++) begin
         rx_bit = 1'($urandom);
         q_full = 1'($urandom);
         @(negedge clk);
         check(oct_valid == 1'b0, "R9", "idle clock pulse", int'(oct_valid), 0);
         check(oct_data == m_last, "R9", "idle clock data", int'(oct_data), int'(m_last));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_stb = 1'b0; rx_bit = 1'b0; q_full = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      check(oct_valid == 1'b0, "R1", "reset valid", int'(oct_valid), 0);
      check(oct_data == 8'h00, "R1", "reset data", int'(oct_data), 0);
   endtask

   initial begin
      logic got;
      int   first_at;
      int   second_at;
      int   fourth_at;
      int   seen;
      int   lvl;
      int   len;
      logic [7:0] tx;
      void'($urandom(32'h5EED_1200));

      // steady level: symbols every 8 samples, NRZI all ones
      do_reset();
      first_at = -1; second_at = -1; fourth_at = -1; seen = 0;
      for (int s = 1; s <= 256; s++) begin
         sample(1'b0, (s == 192), (s % 3), "R2", got);
         if (got) begin
            seen = seen + 1;
            if (seen == 1) first_at = s;
            if (seen == 2) second_at = s;
            if (seen == 3) fourth_at = s;
         end
      end
      check(first_at == 64, "R2", "first octet sample index", first_at, 64);
      check(second_at == 128, "R2", "second octet sample index", second_at, 128);
      check(fourth_at == 256, "R8", "octet after a drop", fourth_at, 256);
      check(seen == 3, "R8", "pulse count with one drop", seen, 3);
      check(oct_data == 8'hFF, "R5", "steady level decodes to ones", int'(oct_data), 8'hFF);

      // tone flips every symbol: data bits all zero once locked
      do_reset();
      lvl = 0;
      for (int s = 0; s < 8 * 40; s++) begin
         if ((s % 8) == 4) lvl = 1 - lvl;
         sample(1'(lvl), 1'b0, 1, "R5", got);
      end
      check(oct_data == 8'h00, "R5", "alternating symbols decode to zeros", int'(oct_data), 0);

      // single-sample glitches inside steady symbols are outvoted
      do_reset();
      for (int s = 0; s < 8 * 24; s++) begin
         sample(((s % 8) == 3), 1'b0, 0, "R4", got);
      end

      // random NRZI-coded octets with jittered symbol length and noise
      do_reset();
      lvl = 0;
      for (int k = 0; k < 280; k++) begin
         tx = 8'($urandom);
         for (int i = 0; i < 8; i++) begin
            if (!tx[i]) lvl = 1 - lvl;
            len = 8;
            if (($urandom % 8) == 0) len = 7 + int'($urandom % 3);
            for (int j = 0; j < len; j++) begin
               sample(1'(lvl) ^ (($urandom % 50) == 0),
                      (($urandom % 5) == 0),
                      int'($urandom % 3), "R3", got);
            end
         end
      end

      // reset mid-stream restores the initial state
      do_reset();

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule